// File: doc/BRIEF.md
# Single-Channel Word DMA Engine

This block moves a run of words between one peripheral and a contiguous region of memory without the processor in the loop. Software programs a starting memory address and a word count through a small register window. It then writes a control word that picks the direction and the bus policy and starts the job. The engine raises a bus request only when the peripheral is ready. It waits for the grant before it touches memory, and passes every word through an internal holding register. The address and the remaining count are updated after each word.

Two bus policies are offered. In burst mode the engine keeps the bus for back-to-back words for as long as the peripheral keeps up. In stealing mode it gives the bus back after every word. In either mode the bus is returned early if the peripheral stalls while words remain, and the engine asks again when the peripheral recovers. When the count is used up, the engine releases the bus and waits for the grant to drop. It then raises a completion interrupt that stays up until software acknowledges it.

Top module: `dma_word_engine`

## Requirements
- R1: After reset, `dma_req`, `irq` and every memory and device strobe are low, `mem_addr`, `mem_wdata` and `dev_wdata` are zero, and the status register reads 0.
- R2: Register window selected by `cpu_sel`. 0 is the address register (a write sets the base, a read returns the current address). 1 is the count register (a write sets the word count, a read returns the words left). 2 is control: bit 0 starts a job, bit 1 selects device-to-memory when 1, and bit 2 selects stealing mode when 1. 3 is status: bit 0 is busy and bit 1 is interrupt pending, and any write to it clears the interrupt. `cpu_rdata` shows the register selected in the previous cycle.
- R3: `mem_we`, `mem_re`, `dev_rd` and `dev_wr` are asserted only while `dma_req` and `dma_ack` are both high. Whenever no strobe is active, `mem_addr`, `mem_wdata` and `dev_wdata` are zero.
- R4: A started job raises `dma_req` only while `dev_ready` is high, and issues no memory or device strobe before `dma_ack` is seen.
- R5: Each word moved advances the address register by one and lowers the count register by one.
- R6: In device-to-memory jobs, the k-th word taken from the device (`dev_rd`) is written to base+k. In memory-to-device jobs, the word at base+k is the k-th word presented on `dev_wdata` with `dev_wr`. Memory read data is expected one cycle after `mem_re`.
- R7: When the count reaches zero the engine drops `dma_req`. Once `dma_ack` has fallen, `irq` rises and busy clears. `irq` stays high until a status write.
- R8: In stealing mode `dma_req` is dropped after every word, so a job of N words raises `dma_req` N times.
- R9: In burst mode with the device always ready, `dma_req` rises once and stays high for the whole job.
- R10: If `dev_ready` is low when a word finishes and words remain, `dma_req` drops while busy stays set and the count keeps the remaining words. The job resumes when the device is ready again.
- R11: Starting a job with a count of zero raises `irq` without ever asserting `dma_req`.
- R12: Writes to the address, count or control registers while busy have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_sel | input | 2 | Register select |
| cpu_wdata | input | DW | Register write data |
| cpu_rdata | output | DW | Register read data, one cycle after select |
| irq | output | 1 | Completion interrupt, held until acknowledged |
| dma_req | output | 1 | Bus request to the processor |
| dma_ack | input | 1 | Bus grant from the processor |
| mem_addr | output | AW | Memory address, zero when idle |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after `mem_re` |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| dev_ready | input | 1 | Device has a word (inbound) or room for one (outbound) |
| dev_rdata | input | DW | Word offered by the device |
| dev_rd | output | 1 | Takes the offered word from the device |
| dev_wdata | output | DW | Word delivered to the device |
| dev_wr | output | 1 | Delivers `dev_wdata` to the device |

## Verification
The assertions assume that the bus grant follows the request. The processor keeps `dma_ack` high for as long as `dma_req` stays high and drops it only after the request falls. They also assume that `dev_ready`, once high, stays high until the engine takes or delivers a word. The bench models the processor as a one-cycle echo of the request. Its device raises ready only from the number of queued source words or from a sink-enable flag, and that number changes only on a `dev_rd` strobe or when the driver adds words. Start, count and address writes are applied on falling edges, so each one lands on a single rising edge.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ARM,
    ST_REQ,
    ST_FETCH,
    ST_STORE,
    ST_LOAD,
    ST_CATCH,
    ST_PUT,
    ST_REL
  } dma_state_e;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  localparam int CTRL_GO    = 0;
  localparam int CTRL_DIR   = 1;
  localparam int CTRL_STEAL = 2;
endpackage

// File: rtl/dma_regif.sv
module dma_regif
  import dma_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_we,
  input  logic [1:0]    cpu_sel,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          busy,
  input  logic [DW-1:0] cur_addr,
  input  logic [DW-1:0] cur_cnt,
  input  logic          set_irq,
  output logic          ld_addr,
  output logic          ld_cnt,
  output logic          go,
  output logic          go_dir,
  output logic          go_steal,
  output logic          irq,
  output logic [DW-1:0] cpu_rdata
);
  logic          irq_q;
  logic [DW-1:0] rd_nxt;
  logic          clr_irq;

  assign ld_addr  = cpu_we && (cpu_sel == SEL_ADDR) && !busy;
  assign ld_cnt   = cpu_we && (cpu_sel == SEL_CNT) && !busy;
  assign go       = cpu_we && (cpu_sel == SEL_CTRL) && cpu_wdata[CTRL_GO] && !busy;
  assign go_dir   = cpu_wdata[CTRL_DIR];
  assign go_steal = cpu_wdata[CTRL_STEAL];
  assign clr_irq  = cpu_we && (cpu_sel == SEL_STAT);
  assign irq      = irq_q;

  always_ff @(posedge clk) begin
    if (rst)          irq_q <= 1'b0;
    else if (set_irq) irq_q <= 1'b1;
    else if (clr_irq) irq_q <= 1'b0;
  end

  always_comb begin
    rd_nxt = '0;
    case (cpu_sel)
      SEL_ADDR: rd_nxt = cur_addr;
      SEL_CNT:  rd_nxt = cur_cnt;
      SEL_STAT: begin
        rd_nxt[0] = busy;
        rd_nxt[1] = irq_q;
      end
      default:  rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cpu_rdata <= '0;
    else     cpu_rdata <= rd_nxt;
  end

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !clr_irq) |=> irq_q);
endmodule

// File: rtl/dma_datapath.sv
module dma_datapath #(
  parameter int DW = 16,
  parameter int AW = 12,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_addr,
  input  logic          ld_cnt,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_cnt,
  input  logic          go,
  input  logic          go_dir,
  input  logic          go_steal,
  input  logic          step,
  input  logic          cap_dev,
  input  logic          cap_mem,
  input  logic [DW-1:0] dev_rdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] cnt_q,
  output logic [DW-1:0] buf_q,
  output logic          dir_q,
  output logic          steal_q,
  output logic          cnt_zero,
  output logic          cnt_last
);
  localparam logic [AW-1:0] ADDR_INC = AW'(1);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (step) begin
      addr_q <= addr_q + ADDR_INC;
      cnt_q  <= cnt_q - CNT_ONE;
    end else begin
      if (ld_addr) addr_q <= wr_addr;
      if (ld_cnt)  cnt_q  <= wr_cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= 1'b0;
      steal_q <= 1'b0;
    end else if (go) begin
      dir_q   <= go_dir;
      steal_q <= go_steal;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          buf_q <= '0;
    else if (cap_dev) buf_q <= dev_rdata;
    else if (cap_mem) buf_q <= mem_rdata;
  end

  assign cnt_zero = (cnt_q == '0);
  assign cnt_last = (cnt_q == CNT_ONE);

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    $past(step) |-> (addr_q == $past(addr_q) + ADDR_INC));
  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    $past(step) |-> (cnt_q == $past(cnt_q) - CNT_ONE));
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic cnt_zero,
  input  logic cnt_last,
  input  logic dir_d2m,
  input  logic steal,
  input  logic dev_ready,
  input  logic dma_ack,
  output logic dma_req,
  output logic busy,
  output logic step,
  output logic cap_dev,
  output logic cap_mem,
  output logic set_irq,
  output logic mem_we,
  output logic mem_re,
  output logic dev_rd,
  output logic dev_wr
);
  dma_state_e st, nxt;
  logic       keep;

  assign keep = !cnt_last && !steal && dev_ready;

  always_comb begin
    nxt     = st;
    step    = 1'b0;
    cap_dev = 1'b0;
    cap_mem = 1'b0;
    set_irq = 1'b0;
    case (st)
      ST_IDLE: if (go) begin
        if (cnt_zero) set_irq = 1'b1;
        else          nxt = ST_ARM;
      end
      ST_ARM:   if (dev_ready) nxt = ST_REQ;
      ST_REQ:   if (dma_ack) nxt = dir_d2m ? ST_FETCH : ST_LOAD;
      ST_FETCH: begin
        cap_dev = 1'b1;
        nxt     = ST_STORE;
      end
      ST_STORE: begin
        step = 1'b1;
        nxt  = keep ? ST_FETCH : ST_REL;
      end
      ST_LOAD:  nxt = ST_CATCH;
      ST_CATCH: begin
        cap_mem = 1'b1;
        nxt     = ST_PUT;
      end
      ST_PUT: begin
        step = 1'b1;
        nxt  = keep ? ST_LOAD : ST_REL;
      end
      ST_REL: if (!dma_ack) begin
        set_irq = cnt_zero;
        nxt     = cnt_zero ? ST_IDLE : ST_ARM;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= nxt;
  end

  assign dma_req = (st == ST_REQ) || (st == ST_FETCH) || (st == ST_STORE) ||
                   (st == ST_LOAD) || (st == ST_CATCH) || (st == ST_PUT);
  assign busy    = (st != ST_IDLE);
  assign mem_we  = (st == ST_STORE);
  assign mem_re  = (st == ST_LOAD);
  assign dev_rd  = (st == ST_FETCH);
  assign dev_wr  = (st == ST_PUT);

  // R3
  bus_owner_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we || mem_re || dev_rd || dev_wr) |-> (dma_ack && dma_req));
  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_we, mem_re, dev_rd, dev_wr}));
  // R8
  steal_release_chk: assert property (@(posedge clk) disable iff (rst)
    (steal && $past(step)) |-> !dma_req);
  // R4
  req_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_req) |-> $past(dev_ready));
endmodule

// File: rtl/dma_word_engine.sv
module dma_word_engine
  import dma_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_we,
  input  logic [1:0]    cpu_sel,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          irq,
  output logic          dma_req,
  input  logic          dma_ack,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic          dev_ready,
  input  logic [DW-1:0] dev_rdata,
  output logic          dev_rd,
  output logic [DW-1:0] dev_wdata,
  output logic          dev_wr
);
  logic          ld_addr, ld_cnt, go, go_dir, go_steal, set_irq;
  logic          busy, step, cap_dev, cap_mem;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] buf_q;
  logic          dir_q, steal_q, cnt_zero, cnt_last;

  dma_regif #(.DW(DW)) u_regif (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_sel(cpu_sel),
    .cpu_wdata(cpu_wdata), .busy(busy),
    .cur_addr(DW'(addr_q)), .cur_cnt(DW'(cnt_q)), .set_irq(set_irq),
    .ld_addr(ld_addr), .ld_cnt(ld_cnt), .go(go), .go_dir(go_dir),
    .go_steal(go_steal), .irq(irq), .cpu_rdata(cpu_rdata)
  );

  dma_datapath #(.DW(DW), .AW(AW), .CW(CW)) u_path (
    .clk(clk), .rst(rst), .ld_addr(ld_addr), .ld_cnt(ld_cnt),
    .wr_addr(cpu_wdata[AW-1:0]), .wr_cnt(cpu_wdata[CW-1:0]),
    .go(go), .go_dir(go_dir), .go_steal(go_steal), .step(step),
    .cap_dev(cap_dev), .cap_mem(cap_mem), .dev_rdata(dev_rdata),
    .mem_rdata(mem_rdata), .addr_q(addr_q), .cnt_q(cnt_q), .buf_q(buf_q),
    .dir_q(dir_q), .steal_q(steal_q), .cnt_zero(cnt_zero), .cnt_last(cnt_last)
  );

  dma_engine u_fsm (
    .clk(clk), .rst(rst), .go(go), .cnt_zero(cnt_zero), .cnt_last(cnt_last),
    .dir_d2m(dir_q), .steal(steal_q), .dev_ready(dev_ready), .dma_ack(dma_ack),
    .dma_req(dma_req), .busy(busy), .step(step), .cap_dev(cap_dev),
    .cap_mem(cap_mem), .set_irq(set_irq), .mem_we(mem_we), .mem_re(mem_re),
    .dev_rd(dev_rd), .dev_wr(dev_wr)
  );

  assign mem_addr  = (mem_we || mem_re) ? addr_q : '0;
  assign mem_wdata = mem_we ? buf_q : '0;
  assign dev_wdata = dev_wr ? buf_q : '0;

  // R7
  irq_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (cnt_q == '0));
  // R7
  irq_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (!dma_req && !busy));
endmodule

// File: tb/tb_dma_word_engine.sv
`timescale 1ns/1ps
module tb_dma_word_engine;
  localparam int DW = 16;
  localparam int AW = 12;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_we = 1'b0;
  logic [1:0]    cpu_sel = 2'd0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic          irq, dma_req;
  logic          dma_ack = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_we, mem_re;
  logic          dev_ready;
  logic [DW-1:0] dev_rdata;
  logic          dev_rd, dev_wr;
  logic [DW-1:0] dev_wdata;

  int checks = 0;
  int errors = 0;
  int rises = 0;
  logic req_prev = 1'b0;

  logic [DW-1:0] src_buf [64];
  int src_wr = 0;
  int src_rd = 0;
  logic d2m_mode = 1'b1;
  logic sink_en = 1'b0;
  logic [DW-1:0] mem [256];
  logic [AW+DW-1:0] exp_mem [$];
  logic [DW-1:0] exp_dev [$];

  always #2.5 clk = ~clk;

  dma_word_engine #(.DW(DW), .AW(AW), .CW(CW)) dut (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_sel(cpu_sel),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq),
    .dma_req(dma_req), .dma_ack(dma_ack), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .mem_re(mem_re), .dev_ready(dev_ready), .dev_rdata(dev_rdata),
    .dev_rd(dev_rd), .dev_wdata(dev_wdata), .dev_wr(dev_wr)
  );

  assign dev_ready = d2m_mode ? (src_rd < src_wr) : sink_en;
  assign dev_rdata = src_buf[src_rd[5:0]];

  // processor grant model and memory / device models
  always @(posedge clk) begin
    dma_ack <= rst ? 1'b0 : dma_req;
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
    if (dev_rd) src_rd <= src_rd + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (dma_req && !req_prev) rises++;
      req_prev = dma_req;
      if (mem_we) begin
        if (exp_mem.size() == 0) chk("R6 unexpected write", {4'h0, mem_addr, mem_wdata}, 32'hFFFFFFFF);
        else chk("R6 memory write", {4'h0, mem_addr, mem_wdata}, {4'h0, exp_mem.pop_front()});
      end
      if (dev_wr) begin
        if (exp_dev.size() == 0) chk("R6 unexpected device word", {16'h0, dev_wdata}, 32'hFFFFFFFF);
        else chk("R6 device word", {16'h0, dev_wdata}, {16'h0, exp_dev.pop_front()});
      end
      if ((mem_we || mem_re || dev_rd || dev_wr) && !(dma_req && dma_ack))
        chk("R3 strobe without ownership", 32'd1, 32'd0);
      if (!(mem_we || mem_re || dev_rd || dev_wr) && (mem_addr != '0 || mem_wdata != '0 || dev_wdata != '0))
        chk("R3 idle bus not zero", {4'h0, mem_addr, mem_wdata}, 32'd0);
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [DW-1:0] d);
    @(negedge clk);
    cpu_sel = sel; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [DW-1:0] d);
    @(negedge clk);
    cpu_sel = sel;
    @(negedge clk);
    d = cpu_rdata;
  endtask

  task automatic push_dev(input logic [AW-1:0] a, input logic [DW-1:0] d);
    src_buf[src_wr[5:0]] = d;
    exp_mem.push_back({a, d});
    src_wr = src_wr + 1;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (irq) break;
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 req", {31'd0, dma_req}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 strobes", {28'd0, mem_we, mem_re, dev_rd, dev_wr}, 0);
    chk("R1 mem_addr", {20'd0, mem_addr}, 0);
    rd(2'd3, v);
    chk("R1 status", {16'd0, v}, 0);

    // R11 zero-count start
    wr(2'd1, 16'd0);
    rises = 0;
    wr(2'd2, 16'h0003);
    repeat (3) @(negedge clk);
    chk("R11 irq on zero count", {31'd0, irq}, 1);
    chk("R11 no request", rises, 0);
    rd(2'd3, v);
    chk("R2 status irq pending not busy", {16'd0, v}, 32'h2);
    wr(2'd3, 16'h0);
    @(negedge clk);
    chk("R7 irq cleared by status write", {31'd0, irq}, 0);

    // R9 burst device-to-memory
    d2m_mode = 1'b1;
    wr(2'd0, 16'h0020);
    wr(2'd1, 16'd4);
    for (int i = 0; i < 4; i++) push_dev(AW'(12'h020 + i), 16'hA000 + 16'(i));
    rises = 0;
    wr(2'd2, 16'h0003);
    wait_irq();
    chk("R7 irq at completion", {31'd0, irq}, 1);
    chk("R9 single request in burst", rises, 1);
    chk("R6 all burst words written", exp_mem.size(), 0);
    rd(2'd0, v);
    chk("R5 address after burst", {16'd0, v}, 32'h24);
    rd(2'd1, v);
    chk("R5 count after burst", {16'd0, v}, 0);
    rd(2'd3, v);
    chk("R7 status after burst", {16'd0, v}, 32'h2);
    repeat (4) @(negedge clk);
    chk("R7 irq held until acknowledged", {31'd0, irq}, 1);
    wr(2'd3, 16'h0);

    // R10 stall with words left, R12 writes ignored while busy
    wr(2'd0, 16'h0040);
    wr(2'd1, 16'd4);
    push_dev(AW'(12'h040), 16'hB000);
    push_dev(AW'(12'h041), 16'hB001);
    rises = 0;
    wr(2'd2, 16'h0003);
    repeat (20) @(negedge clk);
    chk("R10 request dropped on stall", {31'd0, dma_req}, 0);
    chk("R10 no irq while words remain", {31'd0, irq}, 0);
    rd(2'd1, v);
    chk("R10 remaining count", {16'd0, v}, 2);
    rd(2'd0, v);
    chk("R5 address after two words", {16'd0, v}, 32'h42);
    rd(2'd3, v);
    chk("R10 still busy", {16'd0, v}, 32'h1);
    wr(2'd0, 16'h007F);
    wr(2'd1, 16'd9);
    wr(2'd2, 16'h0005);
    rd(2'd0, v);
    chk("R12 address write ignored", {16'd0, v}, 32'h42);
    rd(2'd1, v);
    chk("R12 count write ignored", {16'd0, v}, 2);
    push_dev(AW'(12'h042), 16'hB002);
    push_dev(AW'(12'h043), 16'hB003);
    wait_irq();
    chk("R10 resumed and completed", {31'd0, irq}, 1);
    chk("R10 second request after stall", rises, 2);
    chk("R6 all stalled-job words written", exp_mem.size(), 0);
    wr(2'd3, 16'h0);

    // R8 stealing memory-to-device
    d2m_mode = 1'b0;
    sink_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      mem[8'hA0 + i] = 16'hC0DE + 16'(i * 7);
      exp_dev.push_back(16'hC0DE + 16'(i * 7));
    end
    wr(2'd0, 16'h00A0);
    wr(2'd1, 16'd3);
    rises = 0;
    wr(2'd2, 16'h0005);
    wait_irq();
    chk("R7 irq after stealing job", {31'd0, irq}, 1);
    chk("R8 one request per word", rises, 3);
    chk("R6 all device words delivered", exp_dev.size(), 0);
    rd(2'd0, v);
    chk("R5 address after stealing job", {16'd0, v}, 32'hA3);
    wr(2'd3, 16'h0);
    rd(2'd3, v);
    chk("R2 status clear at end", {16'd0, v}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule